// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair Registers

This unit performs integer multiplication and division for a 32-bit processor core. It keeps its results in its own pair of result registers: an upper word and a lower word. A multiply writes the full double-width product across the pair. A divide writes the quotient to the lower word and the remainder to the upper word. Commands are signed or unsigned. Each one is accepted with a single-cycle start pulse and then runs for a fixed number of iterations while a busy flag is high.

The core reads the stored words through a read port. A read request that arrives while an operation is in flight is held off: valid stays low until the operation finishes, and the read then returns the new value. Multiplication uses a shift-add datapath. Division uses a restoring datapath that works on magnitudes, and a final step corrects the signs. Division by zero produces a fixed result and raises no error.

Top module: `muldiv_unit`

## Requirements
- R1: Signed multiply (op 2'b00): the upper word receives bits 63..32 and the lower word bits 31..0 of the two's-complement product of the operands.
- R2: Unsigned multiply (op 2'b01): the upper and lower words receive the two halves of the unsigned 64-bit product.
- R3: Signed divide (op 2'b10): the lower word receives the quotient truncated toward zero, and the upper word the remainder carrying the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: Unsigned divide (op 2'b11): the lower word receives the unsigned quotient and the upper word the unsigned remainder.
- R5: A divide with a zero divisor, signed or unsigned, sets the lower word to 0xFFFFFFFF and the upper word to the dividend unchanged.
- R6: A start seen while idle is accepted at that clock edge. Busy is high from the next cycle for exactly 32 cycles. The result words change at the edge where busy falls.
- R7: A start while busy is ignored. It does not change the running result, the busy length or the operands in use.
- R8: With a read request, select 0 returns the lower word and select 1 the upper word. Valid equals the request while the unit is idle.
- R9: A read request while busy sees valid low. Once busy falls, the same request sees valid high with the newly written word.
- R10: After reset, busy is low and both result words read 0.
- R11: The result words hold their value in every cycle except the completion edge, whatever the read and operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | 32 | First operand / dividend |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Operation in progress |
| rd_req_i | input | 1 | Read request |
| rd_sel_i | input | 1 | 0 selects lower word, 1 selects upper word |
| rd_valid_o | output | 1 | Read data valid this cycle |
| rd_data_o | output | 32 | Read data |

## Verification
The multiply and divide paths are tried with operands of every sign combination. Mixed signs tell apart the negation of the product from that of the quotient, and like signs show that no correction is applied. Extreme values (0x80000000 squared, all-ones times all-ones unsigned, and the signed overflow divide) separate signed from unsigned handling and expose any lost carry. A dividend smaller than its divisor, and a zero divisor in both signednesses, cover the remainder-only result and the fixed fault result. A start pulse in the middle of a run, and a read request held across a run, separate the command guard and the read stall from the normal path.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/md_seq.sv
module md_seq #(
  parameter int ITER = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = $clog2(ITER + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign last_o = busy_q && (cnt_q == CW'(ITER - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (last_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/md_mul_iter.sv
module md_mul_iter #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W:0]    sum;

  // add multiplicand into upper half when low bit set, then shift right
  assign sum        = {1'b0, prod_q[PW-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  assign prod_nxt_o = {sum, prod_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q <= prod_nxt_o;
    end
  end
endmodule

// File: rtl/md_div_iter.sv
module md_div_iter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  logic [W-1:0] dvs_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W:0]   trial;
  logic         fit;

  // restoring step: dividend bits leave quo_q at the top, quotient bits enter at the bottom
  assign trial     = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
  assign fit       = ~trial[W];
  assign rem_nxt_o = fit ? trial[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
  assign quo_nxt_o = {quo_q[W-2:0], fit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      dvs_q <= dvs_i;
      rem_q <= '0;
      quo_q <= dvd_i;
    end else if (step_i) begin
      rem_q <= rem_nxt_o;
      quo_q <= quo_nxt_o;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  input  logic         rd_req_i,
  input  logic         rd_sel_i,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int ITER = W;
  localparam int PW   = 2 * W;

  md_op_e       op_cmd;
  logic         accept, last;
  logic         cmd_signed, cmd_div, a_neg, b_neg;
  logic [W-1:0] mag_a, mag_b;

  logic         is_div_q, neg_lo_q, neg_rem_q, dz_q;
  logic [W-1:0] dvd_q;
  logic [W-1:0] hi_q, lo_q;

  logic [PW-1:0] prod_nxt, prod_fix;
  logic [W-1:0]  quo_nxt, rem_nxt, quo_fix, rem_fix;

  assign op_cmd     = md_op_e'(op_i);
  assign accept     = start_i & ~busy_o;
  assign cmd_signed = (op_cmd == OP_MUL) || (op_cmd == OP_DIV);
  assign cmd_div    = (op_cmd == OP_DIV) || (op_cmd == OP_DIVU);
  assign a_neg      = cmd_signed & a_i[W-1];
  assign b_neg      = cmd_signed & b_i[W-1];
  assign mag_a      = a_neg ? ('0 - a_i) : a_i;
  assign mag_b      = b_neg ? ('0 - b_i) : b_i;

  md_seq #(.ITER(ITER)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (start_i),
    .busy_o (busy_o),
    .last_o (last)
  );

  md_mul_iter #(.W(W)) u_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept & ~cmd_div),
    .step_i     (busy_o & ~is_div_q),
    .mcand_i    (mag_b),
    .mplier_i   (mag_a),
    .prod_nxt_o (prod_nxt)
  );

  md_div_iter #(.W(W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept & cmd_div),
    .step_i    (busy_o & is_div_q),
    .dvd_i     (mag_a),
    .dvs_i     (mag_b),
    .quo_nxt_o (quo_nxt),
    .rem_nxt_o (rem_nxt)
  );

  // command attributes captured at accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_div_q  <= 1'b0;
      neg_lo_q  <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
      dvd_q     <= '0;
    end else if (accept) begin
      is_div_q  <= cmd_div;
      neg_lo_q  <= a_neg ^ b_neg;
      neg_rem_q <= a_neg;
      dz_q      <= cmd_div && (b_i == '0);
      dvd_q     <= a_i;
    end
  end

  assign prod_fix = neg_lo_q  ? ('0 - prod_nxt) : prod_nxt;
  assign quo_fix  = neg_lo_q  ? ('0 - quo_nxt)  : quo_nxt;
  assign rem_fix  = neg_rem_q ? ('0 - rem_nxt)  : rem_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last) begin
      if (!is_div_q) begin
        hi_q <= prod_fix[PW-1:W];
        lo_q <= prod_fix[W-1:0];
      end else if (dz_q) begin
        hi_q <= dvd_q;
        lo_q <= '1;
      end else begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end
    end
  end

  assign rd_valid_o = rd_req_i & ~busy_o;
  assign rd_data_o  = rd_sel_i ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W    = 32,
  parameter int ITER = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         rd_req_i,
  input logic         rd_sel_i,
  input logic         rd_valid_o,
  input logic [W-1:0] rd_data_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int CW = $clog2(ITER + 2);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_cnt < CW'(ITER));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == CW'(ITER));

  p_busy_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(hi_q) && $stable(lo_q)));

  p_rd_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && busy_o) |-> !rd_valid_o);

  p_rd_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o == (rd_sel_i ? hi_q : lo_q)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W), .ITER(ITER)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .rd_req_i   (rd_req_i),
  .rd_sel_i   (rd_sel_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .hi_q       (hi_q),
  .lo_q       (lo_q)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h0000_0007, 32'hFFFF_FFFD},
    '{2'b00, 32'h8000_0000, 32'h8000_0000},
    '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'b00, 32'h0000_0000, 32'hDEAD_BEEF},
    '{2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'b01, 32'h1234_5678, 32'h9ABC_DEF0},
    '{2'b10, 32'hFFFF_FFF9, 32'h0000_0002},
    '{2'b10, 32'h0000_0007, 32'hFFFF_FFFE},
    '{2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE},
    '{2'b10, 32'h8000_0000, 32'hFFFF_FFFF},
    '{2'b11, 32'hFFFF_FFFF, 32'h0000_0010},
    '{2'b11, 32'h0000_0005, 32'h0000_0007},
    '{2'b11, 32'h8765_4321, 32'h0001_0003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .op_i       (op),
    .a_i        (a),
    .b_i        (b),
    .busy_o     (busy),
    .rd_req_i   (rd_req),
    .rd_sel_i   (rd_sel),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  // returns {upper word, lower word}
  function automatic logic [63:0] model(input logic [1:0] mop, input logic [31:0] ma, input logic [31:0] mb);
    longint sa, sb, q, r;
    sa = longint'($signed(ma));
    sb = longint'($signed(mb));
    case (mop)
      2'b00: return 64'(sa * sb);
      2'b01: return {32'b0, ma} * {32'b0, mb};
      2'b10: begin
        if (mb == 0) return {ma, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {32'(r), 32'(q)};
      end
      default: begin
        if (mb == 0) return {ma, 32'hFFFF_FFFF};
        return {ma % mb, ma / mb};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] mop);
    case (mop)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_pair(output logic [31:0] hi, output logic [31:0] lo);
    rd_req = 1'b1;
    rd_sel = 1'b0;
    #1 lo = rd_data;
    rd_sel = 1'b1;
    #1 hi = rd_data;
    rd_req = 1'b0;
    rd_sel = 1'b0;
  endtask

  // issue at a negedge, optional stray start mid-run; returns after busy has fallen
  task automatic run_op(input logic [1:0] mop, input logic [31:0] ma, input logic [31:0] mb, input bit stray);
    @(negedge clk);
    start = 1'b1; op = mop; a = ma; b = mb;
    @(negedge clk);
    start = 1'b0; a = 32'h5A5A_5A5A; b = 32'h0;
    check(busy === 1'b1, "R6 busy after accept", 64'(busy), 64'd1);
    for (int i = 0; i < 31; i++) begin
      @(negedge clk);
      if (stray && i == 10) begin
        start = 1'b1; op = ~mop; a = 32'h1111_1111; b = 32'h3;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(busy === 1'b1, "R6 busy in cycle 32", 64'(busy), 64'd1);
    @(negedge clk);
    check(busy === 1'b0, "R6 busy clear after 32", 64'(busy), 64'd0);
  endtask

  logic [31:0] hi, lo;
  logic [63:0] exp;

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R10 busy", 64'(busy), 64'd0);
    read_pair(hi, lo);
    check({hi, lo} === 64'd0, "R10 words", {hi, lo}, 64'd0);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].op, VECS[v].a, VECS[v].b, 1'b0);
      read_pair(hi, lo);
      exp = model(VECS[v].op, VECS[v].a, VECS[v].b);
      check(lo === exp[31:0], req_of(VECS[v].op), 64'(lo), 64'(exp[31:0]));
      check(hi === exp[63:32], req_of(VECS[v].op), 64'(hi), 64'(exp[63:32]));
    end

    // R3 overflow corner, fixed expectation
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    read_pair(hi, lo);
    check({hi, lo} === {32'h0, 32'h8000_0000}, "R3 overflow", {hi, lo}, {32'h0, 32'h8000_0000});

    // R5 divide by zero, both signednesses
    run_op(2'b10, 32'hFFFF_FFFB, 32'h0, 1'b0);
    read_pair(hi, lo);
    check({hi, lo} === {32'hFFFF_FFFB, 32'hFFFF_FFFF}, "R5 signed", {hi, lo}, {32'hFFFF_FFFB, 32'hFFFF_FFFF});
    run_op(2'b11, 32'h0000_0064, 32'h0, 1'b0);
    read_pair(hi, lo);
    check({hi, lo} === {32'h0000_0064, 32'hFFFF_FFFF}, "R5 unsigned", {hi, lo}, {32'h0000_0064, 32'hFFFF_FFFF});

    // R7 stray start mid-run leaves result and length unchanged
    run_op(2'b01, 32'h0001_0000, 32'h0003_0005, 1'b1);
    read_pair(hi, lo);
    exp = model(2'b01, 32'h0001_0000, 32'h0003_0005);
    check({hi, lo} === exp, "R7 stray start", {hi, lo}, exp);
    @(negedge clk);
    check(busy === 1'b0, "R7 no late accept", 64'(busy), 64'd0);

    // R9 read held across a run
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 1'b1;
    start = 1'b1; op = 2'b00; a = 32'hFFFF_FFFE; b = 32'h4000_0000;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    check(rd_valid === 1'b0, "R9 stall valid", 64'(rd_valid), 64'd0);
    repeat (17) @(negedge clk);
    exp = model(2'b00, 32'hFFFF_FFFE, 32'h4000_0000);
    check(rd_valid === 1'b1, "R9 released", 64'(rd_valid), 64'd1);
    check(rd_data === exp[63:32], "R9 new upper word", 64'(rd_data), 64'(exp[63:32]));
    // R8 select 0 gives lower word
    rd_sel = 1'b0;
    #1 check(rd_data === exp[31:0], "R8 lower select", 64'(rd_data), 64'(exp[31:0]));
    rd_req = 1'b0;
    #1 check(rd_valid === 1'b0, "R8 no request", 64'(rd_valid), 64'd0);

    // R11 idle with toggling inputs and reads leaves words unchanged
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a = 32'(i * 32'h0101_0101); b = ~a; op = 2'(i);
      rd_req = i[0]; rd_sel = i[1];
    end
    @(negedge clk);
    read_pair(hi, lo);
    check({hi, lo} === exp, "R11 hold", {hi, lo}, exp);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule